// File: doc/BRIEF.md
# Event Timer Main Counter and Register File

This block is the shared core of a multi-channel event timer. It holds one 64-bit main counter and the 32-bit register file, which takes up a 1 KiB address window. Software reaches a small set of global registers: an identity and capability word, a tick period, a global configuration, an interrupt status word and the counter itself. Each timer channel has a 32-byte slot with a configuration word, a 64-bit comparator and a 64-bit message route. Every 64-bit quantity is reached as two 32-bit halves. The bus carries word addresses, so only aligned 32-bit accesses exist.

The counter advances by one on each cycle where the global enable is set and the tick strobe is high. Clearing the global enable freezes the counter at its current value. Setting the enable again resumes counting from that held value. The block does not compare the counter with the comparators, and it does not route interrupts. It only drives the stored channel state and single-cycle arm and disarm strobes to the channel logic. When the global enable is set, every channel whose comparator is not all ones is armed. When the global enable is cleared, every channel is disarmed and the interrupt status is wiped.

Reads are registered: the data for a read strobed in one cycle is on `rdata_o` in the next cycle.

Top module: `evt_regblk`

## Requirements
- R1: After reset the counter is zero, the global configuration and the interrupt status are zero, every comparator is all ones, every stored channel configuration bit is zero, every route is zero, and the arm and disarm strobes are low.
- R2: Byte offset 0x000 reads {VENDOR[15:0], bit15=1 (legacy routing supported), bit14=0, bit13=1 (64-bit counter), bits12:8 = NUM_CH-1, bits7:0 = 0x01}. Offset 0x004 reads TICK_FS. Writes to both offsets are ignored.
- R3: At offset 0x010, bit 0 is the global enable and bit 1 is the legacy-route select. All other bits read zero. Offset 0x014 reads zero, and writes to it are ignored.
- R4: While the global enable is set, the counter rises by one on each clock where `tick_i` is high. While the enable is clear, the counter holds its value whatever `tick_i` does.
- R5: A write to 0x0F0 replaces counter bits 31:0 and a write to 0x0F4 replaces bits 63:32. In that cycle the write takes precedence over an increment. Reads of these offsets return the current (live or held) count.
- R6: In the cycle after a write sets the global enable, `arm_o[n]` pulses for one cycle for each channel n whose comparator is not all ones, and stays low for the other channels.
- R7: In the cycle after a write clears the global enable, `disarm_o` pulses high on all channels for one cycle, and at the end of that cycle the interrupt status becomes zero.
- R8: Channel n sits at base 0x100 + 0x20*n. Its configuration is at +0x00 and its capability word at +0x04 (reads INT_CAP, read-only). Its comparator is at +0x08 and +0x0C (low, high). Its route is at +0x10 and +0x14 (low, high). The other words of the slot read zero.
- R9: Channel configuration writes change only the bits in mask 0x7F4E. Bits 4 and 5 always read 1, bit 15 reads MSG_CAP, and bits 31:16 read zero.
- R10: Channel configuration bit 8 selects narrow mode. Writing it as 1 clears the comparator's high half. While it is set, writes to the comparator's high half are ignored.
- R11: Accesses to a channel slot with index NUM_CH or above read zero, and writes to such a slot change no channel state.
- R12: While enabled, a high `sts_set_i[n]` sets status bit n at offset 0x020. Writing 1 to a status bit clears it, and a set in the same cycle wins over the clear. Status bits at and above NUM_CH, and offset 0x024, read zero.
- R13: Read data appears on `rdata_o` in the cycle after `rd_en_i`. Offsets that map to no register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counter advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 ([9:2]) | Word address within the 1 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| sts_set_i | input | NUM_CH | Per-channel interrupt status set requests |
| glb_en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy-route select |
| count_o | output | 64 | Main counter |
| arm_o | output | NUM_CH | One-cycle arm strobes |
| disarm_o | output | NUM_CH | One-cycle disarm strobes |
| ch_cfg_o | output | 16*NUM_CH | Channel configuration words, as read back |
| ch_cmp_o | output | 64*NUM_CH | Channel comparators |
| ch_route_o | output | 64*NUM_CH | Channel message routes |

## Verification
The counter is run from a preset value just below a 32-bit boundary for a known number of ticks. This shows that the carry reaches the high half, and it separates a counter that holds while halted from one that keeps running or restarts from zero. Comparator patterns with only one channel changed from all ones show that arming is selective. Enable and disable pairs separate the arm strobes from the disarm strobes, and the disarm from the status wipe. Configuration writes of all ones, all zeros and a mixed pattern separate the write mask from the fixed read-only bits. Accesses to the first unimplemented slot and to the last slot in the window show the out-of-range guard. A same-cycle set and write-one-to-clear on one status bit shows which of the two takes priority.

// File: rtl/evt_regblk_pkg.sv
package evt_regblk_pkg;

  // Channel configuration: software-writable bits
  localparam logic [15:0] CH_CFG_WMASK = 16'h7F4E;
  localparam int          CH_NARROW_BIT = 8;

  // Word offsets inside a channel slot
  typedef enum logic [2:0] {
    CW_CFG_LO = 3'd0,
    CW_CFG_HI = 3'd1,
    CW_CMP_LO = 3'd2,
    CW_CMP_HI = 3'd3,
    CW_RT_LO  = 3'd4,
    CW_RT_HI  = 3'd5,
    CW_RSV6   = 3'd6,
    CW_RSV7   = 3'd7
  } chan_word_e;

  // Word indices of the global registers (byte offset / 4)
  localparam logic [5:0] GW_CAP_LO = 6'd0;
  localparam logic [5:0] GW_CAP_HI = 6'd1;
  localparam logic [5:0] GW_CFG_LO = 6'd4;
  localparam logic [5:0] GW_STS    = 6'd8;
  localparam logic [5:0] GW_CNT_LO = 6'd60;
  localparam logic [5:0] GW_CNT_HI = 6'd61;

  // First word address of the channel area (0x100 / 32 per slot)
  localparam logic [4:0] CH_SLOT_BASE = 5'd8;

  function automatic logic [31:0] cap_low(input int nch, input logic [15:0] vendor);
    logic [4:0] nfield;
    nfield = 5'(nch - 1);
    return {vendor, 1'b1, 1'b0, 1'b1, nfield, 8'h01};
  endfunction

  function automatic logic [15:0] merge_masked(input logic [15:0] old_v,
                                               input logic [15:0] new_v,
                                               input logic [15:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  function automatic logic [15:0] chan_fixed_bits(input logic msg_cap);
    return {msg_cap, 15'h0030};
  endfunction

endpackage

// File: rtl/evt_main_ctr.sv
module evt_main_ctr #(
  parameter int CW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [CW/2-1:0]   wdata,
  output logic [CW-1:0]     count
);
  localparam int HALF = CW / 2;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q[HALF-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt_q[CW-1:HALF] <= wdata;
    end else if (run && tick) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_glb_regs.sv
module evt_glb_regs #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [1:0]        cfg_wdata,
  input  logic              wr_sts,
  input  logic [NUM_CH-1:0] sts_wdata,
  input  logic [NUM_CH-1:0] sts_set,
  output logic              en,
  output logic              legacy,
  output logic              en_rise,
  output logic              en_fall,
  output logic [NUM_CH-1:0] sts
);
  logic              en_q, en_d1_q, leg_q;
  logic [NUM_CH-1:0] sts_q, sts_keep, sts_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      leg_q   <= 1'b0;
      en_d1_q <= 1'b0;
    end else begin
      en_d1_q <= en_q;
      if (wr_cfg) begin
        en_q  <= cfg_wdata[0];
        leg_q <= cfg_wdata[1];
      end
    end
  end

  assign en_rise = en_q & ~en_d1_q;
  assign en_fall = ~en_q & en_d1_q;

  // write-one-to-clear and disarm wipe, then gated sets (set wins)
  always_comb begin
    sts_keep = sts_q;
    if (wr_sts)  sts_keep = sts_keep & ~sts_wdata;
    if (en_fall) sts_keep = '0;
    sts_new = sts_keep | (sts_set & {NUM_CH{en_q}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_new;
  end

  assign en     = en_q;
  assign legacy = leg_q;
  assign sts    = sts_q;
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_regblk_pkg::*;
#(
  parameter logic        MSG_CAP = 1'b0,
  parameter logic [31:0] INT_CAP = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  word,
  input  logic [31:0] wdata,
  output logic [15:0] cfg,
  output logic [63:0] cmp,
  output logic [63:0] route,
  output logic [31:0] rd_data
);
  logic [15:0] cfg_q;
  logic [63:0] cmp_q, rt_q;
  logic        narrow;
  chan_word_e  w;

  assign w      = chan_word_e'(word);
  assign narrow = cfg_q[CH_NARROW_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      rt_q  <= '0;
    end else if (wr) begin
      unique case (w)
        CW_CFG_LO: begin
          cfg_q <= merge_masked(cfg_q, wdata[15:0], CH_CFG_WMASK);
          if (wdata[CH_NARROW_BIT]) cmp_q[63:32] <= '0;
        end
        CW_CMP_LO: cmp_q[31:0] <= wdata;
        CW_CMP_HI: if (!narrow) cmp_q[63:32] <= wdata;
        CW_RT_LO:  rt_q[31:0]  <= wdata;
        CW_RT_HI:  rt_q[63:32] <= wdata;
        default: ;
      endcase
    end
  end

  assign cfg   = (cfg_q & CH_CFG_WMASK) | chan_fixed_bits(MSG_CAP);
  assign cmp   = cmp_q;
  assign route = rt_q;

  always_comb begin
    unique case (w)
      CW_CFG_LO: rd_data = {16'h0000, cfg};
      CW_CFG_HI: rd_data = INT_CAP;
      CW_CMP_LO: rd_data = cmp_q[31:0];
      CW_CMP_HI: rd_data = cmp_q[63:32];
      CW_RT_LO:  rd_data = rt_q[31:0];
      CW_RT_HI:  rd_data = rt_q[63:32];
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/evt_regblk.sv
module evt_regblk
  import evt_regblk_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  parameter logic [15:0] VENDOR  = 16'h1D0C,
  parameter logic        MSG_CAP = 1'b0,
  parameter logic [31:0] INT_CAP = 32'h00F0_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [9:2]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_CH-1:0]    sts_set_i,
  output logic                 glb_en_o,
  output logic                 legacy_o,
  output logic [63:0]          count_o,
  output logic [NUM_CH-1:0]    arm_o,
  output logic [NUM_CH-1:0]    disarm_o,
  output logic [16*NUM_CH-1:0] ch_cfg_o,
  output logic [64*NUM_CH-1:0] ch_cmp_o,
  output logic [64*NUM_CH-1:0] ch_route_o
);
  localparam int         CNT_W = 64;
  localparam logic [4:0] NCH5  = 5'(NUM_CH);

  // ---------------- address decode ----------------
  logic       is_chan, chan_ok;
  logic [4:0] chan_idx;
  logic [5:0] gword;
  logic [2:0] cword;

  assign is_chan  = |addr_i[9:8];
  assign chan_idx = addr_i[9:5] - CH_SLOT_BASE;
  assign chan_ok  = is_chan && (chan_idx < NCH5);
  assign gword    = addr_i[7:2];
  assign cword    = addr_i[4:2];

  // named internal events (also observed by the checker)
  logic glb_wr, cfg_wr_ev, sts_wr_ev, ctr_wr_lo_ev, ctr_wr_hi_ev, ctr_wr_ev;
  assign glb_wr       = wr_en_i && !is_chan;
  assign cfg_wr_ev    = glb_wr && (gword == GW_CFG_LO);
  assign sts_wr_ev    = glb_wr && (gword == GW_STS);
  assign ctr_wr_lo_ev = glb_wr && (gword == GW_CNT_LO);
  assign ctr_wr_hi_ev = glb_wr && (gword == GW_CNT_HI);
  assign ctr_wr_ev    = ctr_wr_lo_ev | ctr_wr_hi_ev;

  // ---------------- global state ----------------
  logic              en, legacy, en_rise, en_fall;
  logic [NUM_CH-1:0] sts;

  evt_glb_regs #(.NUM_CH(NUM_CH)) u_glb (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cfg    (cfg_wr_ev),
    .cfg_wdata (wdata_i[1:0]),
    .wr_sts    (sts_wr_ev),
    .sts_wdata (wdata_i[NUM_CH-1:0]),
    .sts_set   (sts_set_i),
    .en        (en),
    .legacy    (legacy),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .sts       (sts)
  );

  logic [CNT_W-1:0] count;

  evt_main_ctr #(.CW(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .tick  (tick_i),
    .wr_lo (ctr_wr_lo_ev),
    .wr_hi (ctr_wr_hi_ev),
    .wdata (wdata_i),
    .count (count)
  );

  // ---------------- channels ----------------
  logic [31:0] chan_rd [NUM_CH];
  logic [63:0] chan_cmp [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i && chan_ok && (chan_idx == 5'(i));

    evt_chan_regs #(.MSG_CAP(MSG_CAP), .INT_CAP(INT_CAP)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ch_wr),
      .word    (cword),
      .wdata   (wdata_i),
      .cfg     (ch_cfg_o[16*i +: 16]),
      .cmp     (chan_cmp[i]),
      .route   (ch_route_o[64*i +: 64]),
      .rd_data (chan_rd[i])
    );

    assign ch_cmp_o[64*i +: 64] = chan_cmp[i];
    assign arm_o[i]    = en_rise & ~(&chan_cmp[i]);
    assign disarm_o[i] = en_fall;
  end

  // ---------------- read path ----------------
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (is_chan) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (chan_ok && (chan_idx == 5'(i))) rd_val = chan_rd[i];
      end
    end else begin
      unique case (gword)
        GW_CAP_LO: rd_val = cap_low(NUM_CH, VENDOR);
        GW_CAP_HI: rd_val = TICK_FS;
        GW_CFG_LO: rd_val = {30'd0, legacy, en};
        GW_STS:    rd_val = {{(32-NUM_CH){1'b0}}, sts};
        GW_CNT_LO: rd_val = count[31:0];
        GW_CNT_HI: rd_val = count[63:32];
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign glb_en_o = en;
  assign legacy_o = legacy;
  assign count_o  = count;
endmodule

// File: rtl/evt_regblk_chk.sv
module evt_regblk_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              glb_en,
  input logic [63:0]       count,
  input logic              ctr_wr_lo,
  input logic              ctr_wr_hi,
  input logic [31:0]       wdata,
  input logic [NUM_CH-1:0] arm,
  input logic [NUM_CH-1:0] disarm,
  input logic [NUM_CH-1:0] sts
);
  assert_ctr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !ctr_wr_lo && !ctr_wr_hi) |=> $stable(count));

  assert_ctr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick && !ctr_wr_lo && !ctr_wr_hi) |=> (count == $past(count) + 64'd1));

  assert_ctr_lo_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr_lo |=> (count[31:0] == $past(wdata)));

  assert_ctr_hi_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr_hi |=> (count[63:32] == $past(wdata)));

  assert_arm_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm != '0) |-> $rose(glb_en));

  assert_arm_disarm_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm & disarm) == '0);

  assert_disarm_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_en) |-> (disarm == {NUM_CH{1'b1}}));

  assert_sts_wiped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_en) |=> (sts == '0));

  assert_sts_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (sts == '0) || $rose(glb_en));
endmodule

bind evt_regblk evt_regblk_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_i),
  .glb_en    (glb_en_o),
  .count     (count_o),
  .ctr_wr_lo (ctr_wr_lo_ev),
  .ctr_wr_hi (ctr_wr_hi_ev),
  .wdata     (wdata_i),
  .arm       (arm_o),
  .disarm    (disarm_o),
  .sts       (sts)
);

// File: tb/evt_regblk_tb.sv
module evt_regblk_tb;
  localparam int          NCH     = 3;
  localparam logic [31:0] TICK_FS = 32'd10_000_000;
  localparam logic [15:0] VENDOR  = 16'h1D0C;
  localparam logic [31:0] INT_CAP = 32'h00F0_0000;
  localparam logic [31:0] FIXED   = 32'h0000_0030;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [9:2]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] sts_set = '0, arm, disarm;
  logic glb_en, legacy;
  logic [63:0] count;
  logic [16*NCH-1:0] ch_cfg;
  logic [64*NCH-1:0] ch_cmp, ch_route;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_regblk #(.NUM_CH(NCH), .TICK_FS(TICK_FS), .VENDOR(VENDOR),
               .MSG_CAP(1'b0), .INT_CAP(INT_CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sts_set_i(sts_set),
    .glb_en_o(glb_en), .legacy_o(legacy), .count_o(count), .arm_o(arm),
    .disarm_o(disarm), .ch_cfg_o(ch_cfg), .ch_cmp_o(ch_cmp), .ch_route_o(ch_route)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; sts_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[9:2]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a[9:2];
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 64'd0);
    chk("R1 enable", {63'd0, glb_en}, 64'd0);
    chk("R1 arm/disarm", {58'd0, arm, disarm}, 64'd0);
    for (int i = 0; i < NCH; i++) begin
      chk("R1 cmp", ch_cmp[64*i +: 64], '1);
      chk("R1 route", ch_route[64*i +: 64], 64'd0);
      chk("R1 cfg", {48'd0, ch_cfg[16*i +: 16]}, {32'd0, FIXED});
    end
    rd_chk("R1 status", 10'h020, 32'd0);
    rd_chk("R13 cfg read", 10'h010, 32'd0);
  endtask

  task automatic t_capability();
    logic [31:0] cap;
    do_reset();
    cap = {VENDOR, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};
    rd_chk("R2 cap low", 10'h000, cap);
    rd_chk("R2 period", 10'h004, TICK_FS);
    bus_wr(10'h000, 32'h0);
    bus_wr(10'h004, 32'h1);
    rd_chk("R2 cap low after write", 10'h000, cap);
    rd_chk("R2 period after write", 10'h004, TICK_FS);
  endtask

  task automatic t_glb_cfg();
    do_reset();
    bus_wr(10'h010, 32'hFFFF_FFFC);
    rd_chk("R3 unused bits", 10'h010, 32'd0);
    bus_wr(10'h010, 32'h2);
    chk("R3 legacy pin", {62'd0, legacy, glb_en}, 64'd2);
    rd_chk("R3 legacy readback", 10'h010, 32'h2);
    bus_wr(10'h014, 32'hFFFF_FFFF);
    rd_chk("R3 upper half", 10'h014, 32'd0);
    rd_chk("R3 cfg unchanged", 10'h010, 32'h2);
    rd_chk("R13 unmapped 0x050", 10'h050, 32'd0);
    rd_chk("R13 unmapped 0x0F8", 10'h0F8, 32'd0);
  endtask

  task automatic t_counter();
    do_reset();
    bus_wr(10'h0F0, 32'hFFFF_FFFE);
    bus_wr(10'h0F4, 32'h5);
    bus_wr(10'h010, 32'h1);
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    chk("R4 count with carry", count, 64'h6_0000_0003);
    rd_chk("R5 live low", 10'h0F0, 32'h3);
    rd_chk("R5 live high", 10'h0F4, 32'h6);
    bus_wr(10'h010, 32'h0);
    tick = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 halted holds", count, 64'h6_0000_0003);
    rd_chk("R5 held low", 10'h0F0, 32'h3);
    tick = 1'b0;
    bus_wr(10'h010, 32'h1);
    tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    chk("R4 resumes from held", count, 64'h6_0000_0005);
  endtask

  task automatic t_ctr_write();
    tick = 1'b1;
    bus_wr(10'h0F0, 32'h10);
    chk("R5 write beats increment", count, 64'h6_0000_0010);
    @(negedge clk);
    chk("R5 counting after write", count, 64'h6_0000_0011);
    tick = 1'b0;
    bus_wr(10'h0F4, 32'hABCD);
    chk("R5 high half write", count, 64'hABCD_0000_0011);
  endtask

  task automatic t_arm();
    do_reset();
    bus_wr(10'h128, 32'h100);
    chk("R8 ch1 cmp low", ch_cmp[64 +: 64], 64'hFFFF_FFFF_0000_0100);
    bus_wr(10'h010, 32'h1);
    chk("R6 arm selective", {61'd0, arm}, 64'b010);
    chk("R6 no disarm", {61'd0, disarm}, 64'd0);
    @(negedge clk);
    chk("R6 arm one cycle", {61'd0, arm}, 64'd0);
    bus_wr(10'h010, 32'h0);
    chk("R7 disarm all", {61'd0, disarm}, 64'b111);
    chk("R7 no arm", {61'd0, arm}, 64'd0);
    @(negedge clk);
    chk("R7 disarm one cycle", {61'd0, disarm}, 64'd0);
  endtask

  task automatic t_status();
    do_reset();
    bus_wr(10'h010, 32'h1);
    @(negedge clk); sts_set = 3'b101;
    @(negedge clk); sts_set = '0;
    rd_chk("R12 set bits", 10'h020, 32'h5);
    bus_wr(10'h020, 32'h1);
    rd_chk("R12 write one clears", 10'h020, 32'h4);
    @(negedge clk);
    sts_set = 3'b001; wr_en = 1'b1; addr = 8'h08; wdata = 32'h1;
    @(negedge clk);
    sts_set = '0; wr_en = 1'b0;
    rd_chk("R12 set wins over clear", 10'h020, 32'h5);
    rd_chk("R12 upper word", 10'h024, 32'd0);
    bus_wr(10'h010, 32'h0);
    @(negedge clk);
    rd_chk("R7 status wiped", 10'h020, 32'd0);
    @(negedge clk); sts_set = 3'b111;
    @(negedge clk); sts_set = '0;
    rd_chk("R12 no set while halted", 10'h020, 32'd0);
  endtask

  task automatic t_chan_map();
    do_reset();
    bus_wr(10'h150, 32'hCAFE_0001);
    bus_wr(10'h154, 32'h0000_BEEF);
    rd_chk("R8 route low", 10'h150, 32'hCAFE_0001);
    rd_chk("R8 route high", 10'h154, 32'h0000_BEEF);
    chk("R8 route port", ch_route[128 +: 64], 64'h0000_BEEF_CAFE_0001);
    rd_chk("R8 cmp reset low", 10'h108, 32'hFFFF_FFFF);
    rd_chk("R8 cap word", 10'h104, INT_CAP);
    bus_wr(10'h104, 32'h0);
    rd_chk("R8 cap word read-only", 10'h104, INT_CAP);
    rd_chk("R8 reserved slot word", 10'h118, 32'd0);
  endtask

  task automatic t_cfg_mask();
    do_reset();
    bus_wr(10'h100, 32'hFFFF_FFFF);
    rd_chk("R9 all ones", 10'h100, 32'h0000_7F7E);
    chk("R9 cfg port", {48'd0, ch_cfg[15:0]}, 64'h7F7E);
    bus_wr(10'h100, 32'h0);
    rd_chk("R9 all zeros", 10'h100, FIXED);
    bus_wr(10'h100, 32'h0000_0F0F);
    rd_chk("R9 mixed", 10'h100, 32'h0000_0F3E);
  endtask

  task automatic t_narrow();
    do_reset();
    bus_wr(10'h14C, 32'h1234);
    bus_wr(10'h148, 32'h5678);
    rd_chk("R10 wide high", 10'h14C, 32'h1234);
    bus_wr(10'h140, 32'h100);
    rd_chk("R10 narrow clears high", 10'h14C, 32'd0);
    bus_wr(10'h14C, 32'h9);
    rd_chk("R10 high write ignored", 10'h14C, 32'd0);
    chk("R10 cmp port", ch_cmp[128 +: 64], 64'h5678);
    bus_wr(10'h140, 32'h0);
    bus_wr(10'h14C, 32'h9);
    rd_chk("R10 wide again", 10'h14C, 32'h9);
  endtask

  task automatic t_out_of_range();
    do_reset();
    bus_wr(10'h160, 32'hFFFF_FFFF);
    bus_wr(10'h168, 32'h0);
    bus_wr(10'h3F0, 32'h1);
    rd_chk("R11 slot 3 cfg", 10'h160, 32'd0);
    rd_chk("R11 slot 3 cmp", 10'h168, 32'd0);
    rd_chk("R11 last slot", 10'h3E8, 32'd0);
    for (int i = 0; i < NCH; i++) begin
      chk("R11 channel cfg untouched", {48'd0, ch_cfg[16*i +: 16]}, {32'd0, FIXED});
      chk("R11 channel cmp untouched", ch_cmp[64*i +: 64], '1);
      chk("R11 channel route untouched", ch_route[64*i +: 64], 64'd0);
    end
  endtask

  initial begin
    t_reset();
    t_capability();
    t_glb_cfg();
    t_counter();
    t_ctr_write();
    t_arm();
    t_status();
    t_chan_map();
    t_cfg_mask();
    t_narrow();
    t_out_of_range();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule